// File: doc/BRIEF.md
# GPIO Bank Controller with Grouped Interrupts

This block is a bank of general-purpose I/O lines behind a small register interface with an address, a write strobe, write data and a combinational read data bus. For each line, software sets an output value, a direction, a blink enable and a polarity bit. It reads back the polarity-corrected input value. Outputs go to the pad drivers as a data vector and an output-enable vector. The pad drivers themselves sit outside the block.

Incoming pin levels pass through a two-flop synchronizer. The synchronized value is XORed with the polarity bit to form the corrected input. A rising transition of the corrected input is latched in an edge-cause register, which software clears bit by bit. Both kinds of interrupt use the polarity bit to choose their trigger. A level interrupt fires on a high or low level. An edge interrupt fires on a rising or falling transition.

Level causes (corrected input ANDed with the level mask) and edge causes (latched cause ANDed with the edge mask) are ORed together. Each group of eight adjacent lines feeds one summary interrupt output. Blinking lines drive a shared square wave. Its half period is counted in pulses of an external tick strobe.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous active-low reset, the registers hold these values: output 0, direction all ones (every line an input), blink 0, polarity 0, edge cause 0, edge mask 0 and level mask 0. With these values `pin_oe` is 0 and `irq_grp` is 0.
- R2: The read/write registers sit at these byte offsets: output 0x00, direction 0x04, blink 0x08, polarity 0x0C. Each one reads back the last value written to it. The corrected input reads at 0x10, and writes to 0x10 have no effect. Any unmapped offset reads 0.
- R3: `pin_oe[i]` is the inverse of direction bit i, so a direction bit of 1 makes line i an input. When blink bit i is 0, `pin_out[i]` equals output register bit i.
- R4: The corrected input bit i equals the pin sampled through two flops, XORed with polarity bit i. A pin change shows in a read at 0x10 after the second rising clock edge, and not after the first.
- R5: Edge-cause bit i (offset 0x14) sets when corrected input bit i goes from 0 to 1. With the polarity bit set, this happens on a falling pin. A write to the polarity register by itself never sets a cause bit.
- R6: Writing a 0 to an edge-cause bit clears it. Writing a 1 leaves it unchanged. When a new edge arrives in the same cycle as a clearing write, the bit stays set.
- R7: The level cause of line i is corrected input bit i ANDed with level mask bit i. It is not latched, so it follows the pin.
- R8: `irq_grp[g]` is the OR over lines 8g to 8g+7 of the level cause and of edge-cause bit i ANDed with edge mask bit i. A cause whose mask bit is 0 does not raise any output.
- R9: When blink bit i is 1, `pin_out[i]` follows one phase that all blinking lines share. The phase starts at 0 after reset. It inverts on every HALF_TICKS-th cycle in which `blink_tick` is 1. Cycles without a tick do not advance it.
- R10: The edge-mask register sits at 0x18 + MASK_OFS and the level-mask register at 0x1C + MASK_OFS. Both read back what was written. When MASK_OFS is nonzero, 0x18 and 0x1C are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Combinational read data for `bus_addr` |
| pin_in | input | NLINES | Asynchronous pin levels |
| pin_out | output | NLINES | Output data to pad drivers |
| pin_oe | output | NLINES | Output enable to pad drivers, 1 = drive |
| blink_tick | input | 1 | Timebase strobe for blinking |
| irq_grp | output | NLINES/GRP | Summary interrupt for each group of GRP lines |

## Verification
The bound checker watches the following properties on every cycle:
- The edge-cause register sets a bit only after an observed corrected rise.
- A clearing write leaves no bit set unless a rise arrived in the same cycle.
- A rise is never lost.
- The output enables follow each direction write.
- The interrupt outputs stay low while both masks are zero.
- The blink phase holds in cycles without a tick.

Some behaviours can only be shown by the bench's directed scenarios:
- The exact two-edge latency of the synchronizer.
- The falling-edge capture through polarity.
- The level interrupt following the pin back down.
- The grouping of lines onto the summary outputs.
- The blink half period measured in ticks.
- The relocated mask offsets.

// File: rtl/gpio_bank_pkg.sv
// Package gpio_bank_pkg
// Shared register offsets and the register-select type for the GPIO bank.
// Assumes byte addressing with one 32-bit word per register.
package gpio_bank_pkg;

    localparam int OFS_OUT   = 'h00;
    localparam int OFS_DIR   = 'h04;
    localparam int OFS_BLINK = 'h08;
    localparam int OFS_POL   = 'h0C;
    localparam int OFS_DIN   = 'h10;
    localparam int OFS_CAUSE = 'h14;
    localparam int OFS_EMASK = 'h18;
    localparam int OFS_LMASK = 'h1C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_OUT,
        SEL_DIR,
        SEL_BLINK,
        SEL_POL,
        SEL_DIN,
        SEL_CAUSE,
        SEL_EMASK,
        SEL_LMASK
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
// Module gpio_sync
// Two-flop synchronizer for each asynchronous pin input.
// Assumes each line is an independent level; no bus coherence is promised.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Shift the pin level through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                stab_q <= meta_q;
            end
        end

        assign sync_out[i] = stab_q;
    end
endmodule

// File: rtl/gpio_blink_gen.sv
// Module gpio_blink_gen
// Shared blink phase that inverts once every HALF_TICKS strobes.
// Assumes HALF_TICKS >= 2 and a tick strobe that lasts one cycle.
module gpio_blink_gen #(
    parameter int HALF_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic phase
);
    localparam int CW = $clog2(HALF_TICKS);
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    // Count strobes and invert the phase at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q == LAST) begin
                cnt_q   <= '0;
                phase_q <= ~phase_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/gpio_irq_agg.sv
// Module gpio_irq_agg
// Polarity correction, rising-edge capture and grouped interrupt reduction.
// Assumes sync_pin is already synchronized. The edge is taken on the
// corrected value, with the current polarity applied to both samples.
module gpio_irq_agg #(
    parameter int NLINES = 32,
    parameter int GRP    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NLINES-1:0]      sync_pin,
    input  logic [NLINES-1:0]      pol,
    input  logic                   cause_wr,
    input  logic [NLINES-1:0]      cause_wdata,
    input  logic [NLINES-1:0]      emask,
    input  logic [NLINES-1:0]      lmask,
    output logic [NLINES-1:0]      din,
    output logic [NLINES-1:0]      cause,
    output logic [NLINES-1:0]      rise,
    output logic [NLINES/GRP-1:0]  irq_grp
);
    localparam int NGRP = NLINES / GRP;

    logic [NLINES-1:0] prev_q;
    logic [NLINES-1:0] cause_q;
    logic [NLINES-1:0] masked;

    // Corrected input and a rising edge seen through the same polarity.
    always_comb begin
        din  = sync_pin ^ pol;
        rise = din & ~(prev_q ^ pol);
    end

    // Keep the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_pin;
    end

    // Latch edges; clear bits written as 0; a new edge beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        cause_q <= '0;
        else if (cause_wr) cause_q <= (cause_q & cause_wdata) | rise;
        else               cause_q <= cause_q | rise;
    end

    // Merge masked level and edge causes.
    always_comb masked = (din & lmask) | (cause_q & emask);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign irq_grp[g] = |masked[g*GRP +: GRP];
    end

    assign cause = cause_q;
endmodule

// File: rtl/gpio_irq_bank.sv
// Module gpio_irq_bank
// GPIO bank top: register file, address decode, read mux, pad outputs,
// plus the synchronizer, blink and interrupt sub-blocks.
// Assumes single-cycle writes and a combinational read on bus_addr.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NLINES     = 32,
    parameter int GRP        = 8,
    parameter int AW         = 8,
    parameter int MASK_OFS   = 0,
    parameter int HALF_TICKS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         bus_addr,
    input  logic                  bus_we,
    input  logic [NLINES-1:0]     bus_wdata,
    output logic [NLINES-1:0]     bus_rdata,
    input  logic [NLINES-1:0]     pin_in,
    output logic [NLINES-1:0]     pin_out,
    output logic [NLINES-1:0]     pin_oe,
    input  logic                  blink_tick,
    output logic [NLINES/GRP-1:0] irq_grp
);
    localparam int NGRP = NLINES / GRP;

    reg_sel_e          sel;
    logic [NLINES-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
    logic [NLINES-1:0] sync_pin, din, cause_q, edge_rise;
    logic              blink_phase;
    logic [NGRP-1:0]   grp;

    // Decode the byte offset into a register select.
    always_comb begin
        if      (bus_addr == AW'(OFS_OUT))              sel = SEL_OUT;
        else if (bus_addr == AW'(OFS_DIR))              sel = SEL_DIR;
        else if (bus_addr == AW'(OFS_BLINK))            sel = SEL_BLINK;
        else if (bus_addr == AW'(OFS_POL))              sel = SEL_POL;
        else if (bus_addr == AW'(OFS_DIN))              sel = SEL_DIN;
        else if (bus_addr == AW'(OFS_CAUSE))            sel = SEL_CAUSE;
        else if (bus_addr == AW'(OFS_EMASK + MASK_OFS)) sel = SEL_EMASK;
        else if (bus_addr == AW'(OFS_LMASK + MASK_OFS)) sel = SEL_LMASK;
        else                                            sel = SEL_NONE;
    end

    // Update the software-written control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_OUT:   out_q   <= bus_wdata;
                SEL_DIR:   dir_q   <= bus_wdata;
                SEL_BLINK: blink_q <= bus_wdata;
                SEL_POL:   pol_q   <= bus_wdata;
                SEL_EMASK: emask_q <= bus_wdata;
                SEL_LMASK: lmask_q <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Return the selected register; unmapped offsets read zero.
    always_comb begin
        case (sel)
            SEL_OUT:   bus_rdata = out_q;
            SEL_DIR:   bus_rdata = dir_q;
            SEL_BLINK: bus_rdata = blink_q;
            SEL_POL:   bus_rdata = pol_q;
            SEL_DIN:   bus_rdata = din;
            SEL_CAUSE: bus_rdata = cause_q;
            SEL_EMASK: bus_rdata = emask_q;
            SEL_LMASK: bus_rdata = lmask_q;
            default:   bus_rdata = '0;
        endcase
    end

    gpio_sync #(.W(NLINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_pin)
    );

    gpio_blink_gen #(.HALF_TICKS(HALF_TICKS)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (blink_tick),
        .phase (blink_phase)
    );

    gpio_irq_agg #(.NLINES(NLINES), .GRP(GRP)) u_agg (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_pin    (sync_pin),
        .pol         (pol_q),
        .cause_wr    (bus_we && (sel == SEL_CAUSE)),
        .cause_wdata (bus_wdata),
        .emask       (emask_q),
        .lmask       (lmask_q),
        .din         (din),
        .cause       (cause_q),
        .rise        (edge_rise),
        .irq_grp     (grp)
    );

    // Per line: choose the blink phase or the output register.
    for (genvar i = 0; i < NLINES; i++) begin : g_pad
        assign pin_out[i] = blink_q[i] ? blink_phase : out_q[i];
        assign pin_oe[i]  = ~dir_q[i];
    end

    assign irq_grp = grp;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Module gpio_irq_bank_chk
// Concurrent checks on the GPIO bank, bound into every instance of the top.
// Assumes it sees the top's ports and its internal cause/mask/blink state.
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int GRP    = 8,
    parameter int AW     = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [AW-1:0]         bus_addr,
    input logic                  bus_we,
    input logic [NLINES-1:0]     bus_wdata,
    input logic [NLINES-1:0]     pin_oe,
    input logic [NLINES/GRP-1:0] irq_grp,
    input logic [NLINES-1:0]     cause_q,
    input logic [NLINES-1:0]     edge_rise,
    input logic [NLINES-1:0]     emask_q,
    input logic [NLINES-1:0]     lmask_q,
    input logic                  blink_tick,
    input logic                  blink_phase
);
    // R1: quiet outputs right after reset release
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_grp == '0 && pin_oe == '0));

    // R3: output enables follow a direction write
    a_r3_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_DIR)) |=> (pin_oe == ~$past(bus_wdata)));

    // R5: a cause bit only sets after an observed corrected rise
    a_r5_cause_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(edge_rise)) == '0));

    // R6: a zero write clears every bit that saw no new edge
    a_r6_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFS_CAUSE))
        |=> ((cause_q & ~$past(bus_wdata) & ~$past(edge_rise)) == '0));

    // R6: an edge is never lost, even against a clear
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_rise) & ~cause_q) == '0));

    // R8: no summary interrupt while both masks are zero
    a_r8_masks_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_q == '0 && lmask_q == '0) |-> (irq_grp == '0));

    // R9: blink phase only moves on a tick
    a_r9_phase_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_tick |=> $stable(blink_phase));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
    .NLINES (NLINES),
    .GRP    (GRP),
    .AW     (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .pin_oe      (pin_oe),
    .irq_grp     (irq_grp),
    .cause_q     (cause_q),
    .edge_rise   (edge_rise),
    .emask_q     (emask_q),
    .lmask_q     (lmask_q),
    .blink_tick  (blink_tick),
    .blink_phase (blink_phase)
);

// File: tb/gpio_irq_bank_bench.sv
// Directed bench for gpio_irq_bank: one task per scenario, each self-checking.
module gpio_irq_bank_bench;
    localparam int NL    = 32;
    localparam int AW    = 8;
    localparam int MOFS  = 'h20;
    localparam int HALF  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [NL-1:0] bus_wdata = '0;
    logic [NL-1:0] bus_rdata;
    logic [NL-1:0] pins = '0;
    logic [NL-1:0] pin_out, pin_oe;
    logic          blink_tick = 1'b0;
    logic [3:0]    irq_grp;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gpio_irq_bank #(.NLINES(NL), .GRP(8), .AW(AW), .MASK_OFS(MOFS),
                    .HALF_TICKS(HALF)) u_gpio_irq_bank (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pins),
        .pin_out (pin_out), .pin_oe (pin_oe), .blink_tick (blink_tick),
        .irq_grp (irq_grp)
    );

    task automatic check(input string req, input logic [NL-1:0] act,
                         input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [NL-1:0] d);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [NL-1:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            blink_tick = 1'b1;
            @(negedge clk);
            blink_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [NL-1:0] d;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        rd('h00, d); check("R1 out", d, '0);
        rd('h04, d); check("R1 dir", d, '1);
        rd('h08, d); check("R1 blink", d, '0);
        rd('h14, d); check("R1 cause", d, '0);
        rd('h38, d); check("R1 emask", d, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 irq", NL'(irq_grp), '0);
    endtask

    task automatic t_regs();
        logic [NL-1:0] d;
        wr('h00, 32'h1234_5678); rd('h00, d); check("R2 out", d, 32'h1234_5678);
        wr('h08, 32'h0F0F_0000); rd('h08, d); check("R2 blink", d, 32'h0F0F_0000);
        wr('h0C, 32'hDEAD_BEEF); rd('h0C, d); check("R2 pol", d, 32'hDEAD_BEEF);
        step(2);
        rd('h10, d); check("R4 din inverted", d, 32'hDEAD_BEEF);
        wr('h10, 32'h0); rd('h10, d); check("R2 din write ignored", d, 32'hDEAD_BEEF);
        wr('h0C, '0); wr('h08, '0); wr('h00, '0);
        rd('h14, d); check("R5 pol write no cause", d, '0);
        wr('h38, 32'hA5A5_0001); rd('h38, d); check("R10 emask", d, 32'hA5A5_0001);
        wr('h3C, 32'h5A5A_0002); rd('h3C, d); check("R10 lmask", d, 32'h5A5A_0002);
        rd('h18, d); check("R10 base 0x18 unmapped", d, '0);
        rd('h1C, d); check("R10 base 0x1C unmapped", d, '0);
        rd('h24, d); check("R2 unmapped", d, '0);
        wr('h38, '0); wr('h3C, '0);
    endtask

    task automatic t_dir();
        wr('h04, 32'hFFFF_0000);
        check("R3 pin_oe", pin_oe, 32'h0000_FFFF);
        wr('h00, 32'h0000_00A5);
        check("R3 pin_out", pin_out, 32'h0000_00A5);
        wr('h04, '1); wr('h00, '0);
    endtask

    task automatic t_din();
        logic [NL-1:0] d;
        pins[7] = 1'b1;
        step(1); rd('h10, d); check("R4 after one edge", d, '0);
        step(1); rd('h10, d); check("R4 after two edges", d, 32'h80);
        pins[7] = 1'b0;
        step(3);
        wr('h14, '0);
    endtask

    task automatic t_edge();
        logic [NL-1:0] d;
        pins[2] = 1'b1;
        step(2); rd('h14, d); check("R5 not yet latched", d, '0);
        step(1); rd('h14, d); check("R5 rising", d, 32'h4);
        pins[2] = 1'b0; step(3);
        wr('h14, '0);
        wr('h0C, 32'h40); step(3);
        rd('h14, d); check("R5 polarity alone", d, '0);
        pins[6] = 1'b1; step(3);
        rd('h14, d); check("R5 pin rise with pol", d, '0);
        pins[6] = 1'b0; step(3);
        rd('h14, d); check("R5 falling via pol", d, 32'h40);
        wr('h0C, '0); wr('h14, '0);
        rd('h14, d); check("R6 clear", d, '0);
    endtask

    task automatic t_clear();
        logic [NL-1:0] d;
        pins[3] = 1'b1; pins[7] = 1'b1; step(3);
        wr('h14, ~32'h8); rd('h14, d); check("R6 one keeps", d, 32'h80);
        pins[4] = 1'b1;
        step(2);
        wr('h14, '0); rd('h14, d); check("R6 event wins", d, 32'h10);
        pins[3] = 1'b0; pins[4] = 1'b0; pins[7] = 1'b0; step(3);
        wr('h14, '0);
    endtask

    task automatic t_level();
        wr('h3C, 32'h200);
        pins[9] = 1'b1; step(2);
        check("R7 level high", NL'(irq_grp), 32'h2);
        pins[9] = 1'b0; step(2);
        check("R7 level follows pin", NL'(irq_grp), 32'h0);
        wr('h3C, '0); wr('h14, '0);
    endtask

    task automatic t_group();
        wr('h38, 32'h4002_0000);
        pins[1] = 1'b1; step(3);
        check("R8 unmasked edge quiet", NL'(irq_grp), 32'h0);
        pins[17] = 1'b1; step(3);
        check("R8 group 2", NL'(irq_grp), 32'h4);
        pins[30] = 1'b1; step(3);
        check("R8 groups 2,3", NL'(irq_grp), 32'hC);
        wr('h14, ~32'h0002_0000);
        check("R8 group 2 dropped", NL'(irq_grp), 32'h8);
        pins[1] = 1'b0; pins[17] = 1'b0; pins[30] = 1'b0; step(3);
        wr('h14, '0); wr('h38, '0);
    endtask

    task automatic t_blink();
        wr('h00, 32'h0010_0000);
        wr('h08, 32'h0010_0020);
        check("R9 phase starts low", pin_out, '0);
        ticks(3);
        check("R9 three ticks", pin_out, '0);
        step(5);
        check("R9 idle no advance", pin_out, '0);
        ticks(1);
        check("R9 half period", pin_out, 32'h0010_0020);
        ticks(4);
        check("R9 full period", pin_out, '0);
        wr('h08, '0);
        check("R3 blink off restores out", pin_out, 32'h0010_0000);
        wr('h00, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(1);
        t_reset();
        t_regs();
        t_dir();
        t_din();
        t_edge();
        t_clear();
        t_level();
        t_group();
        t_blink();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule